// File: doc/BRIEF.md
# Keyboard Scan Code Event Decoder

This block sits behind a PS/2 frame receiver and turns the received byte stream into key events. Every byte that is not a prefix becomes one event. The event carries the scan code and a flag that says whether the key went down or came up. The break prefix (0xF0) and the extended prefix (0xE0) give no event of their own. Each one arms a pending flag that is attached to the next ordinary byte.

A 256-bit held-key map holds the down/up state of each scan code. A key that is pressed while already marked held is an automatic (typematic) repeat. The block flags such a repeat, or drops it when the suppression input is high. A receiver frame error clears any pending prefix, so a corrupted byte cannot turn the next code into a release. Mapping codes to characters and tracking shift state are left to the consumer.

Top module: `kbd_event_decoder`

## Requirements
- R1: While reset is low, every output is 0, both pending prefixes are cleared and every held-map bit is cleared.
- R2: A byte accepted with `byte_valid=1` and `frame_err=0`, other than 0xF0 or 0xE0, gives `evt_valid=1` for exactly one cycle, on the clock edge after the byte. On that cycle `evt_code` equals the byte. The `evt_*` fields keep their values between events.
- R3: Byte 0xF0 gives no event and arms a pending release. The next code byte is reported with `evt_release=1`, and the pending release is then cleared.
- R4: Byte 0xE0 gives no event and arms a pending extended flag. The next code byte is reported with `evt_extended=1`. Both prefixes can be pending together (E0 F0 code).
- R5: A press of a code whose held bit is 0 is reported with `evt_repeat=0` and sets the bit. A press of a code whose bit is already 1 is reported with `evt_repeat=1`.
- R6: A release clears the held bit of its code, so the next press of that code has `evt_repeat=0`.
- R7: While `repeat_squash=1`, a press that would have `evt_repeat=1` gives no event. It still clears the pending extended flag. First presses and releases are still reported.
- R8: A `frame_err` pulse clears both pending prefixes. A byte presented in the same cycle as `frame_err` is ignored: it gives no event and does not change the held map.
- R9: An event never has `evt_release` and `evt_repeat` both set.
- R10: With no accepted code byte in a cycle, `evt_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| frame_err | input | 1 | Receiver frame error pulse |
| repeat_squash | input | 1 | Drop typematic repeat events |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_code | output | 8 | Scan code of the event |
| evt_release | output | 1 | 1 = key released, 0 = key pressed |
| evt_repeat | output | 1 | Press of a key already held |
| evt_extended | output | 1 | Code followed an E0 prefix |

## Verification
The hardest state to reach from the ports is a pending prefix that meets something other than a clean code byte. Examples are a frame error that lands between F0 and its code, a byte that arrives together with an error, and a suppressed repeat that consumes an armed extended flag. Directed sequences build each of these cases by hand: E0 F0 code, F0 then an error then a code, and repeats with suppression on. A long random stream follows, drawn from a few codes plus both prefixes, with random errors and random suppression. It is compared every cycle against a behavioural model, so back-to-back prefixes and re-presses of released keys occur many times.

// File: rtl/kbd_event_decoder.sv
module kbd_event_decoder #(
  parameter int         CODE_W     = 8,
  parameter logic [7:0] BREAK_BYTE = 8'hF0,
  parameter logic [7:0] EXT_BYTE   = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [CODE_W-1:0] byte_data,
  input  logic              frame_err,
  input  logic              repeat_squash,
  output logic              evt_valid,
  output logic [CODE_W-1:0] evt_code,
  output logic              evt_release,
  output logic              evt_repeat,
  output logic              evt_extended
);
  localparam int KEYS = 1 << CODE_W;

  logic [KEYS-1:0] held;
  logic            brk_q, ext_q;

  wire take     = byte_valid && !frame_err;
  wire is_brk   = byte_data == BREAK_BYTE[CODE_W-1:0];
  wire is_ext   = byte_data == EXT_BYTE[CODE_W-1:0];
  wire is_code  = take && !is_brk && !is_ext;
  wire was_held = held[byte_data];
  wire again    = was_held && !brk_q;
  wire emit     = is_code && !(again && repeat_squash);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held         <= '0;
      brk_q        <= 1'b0;
      ext_q        <= 1'b0;
      evt_valid    <= 1'b0;
      evt_code     <= '0;
      evt_release  <= 1'b0;
      evt_repeat   <= 1'b0;
      evt_extended <= 1'b0;
    end else begin
      evt_valid <= emit;
      if (frame_err) begin
        brk_q <= 1'b0;
        ext_q <= 1'b0;
      end else if (take) begin
        if (is_brk)       brk_q <= 1'b1;
        else if (is_ext)  ext_q <= 1'b1;
        else begin
          brk_q           <= 1'b0;
          ext_q           <= 1'b0;
          held[byte_data] <= !brk_q;
        end
      end
      if (emit) begin
        evt_code     <= byte_data;
        evt_release  <= brk_q;
        evt_repeat   <= again;
        evt_extended <= ext_q;
      end
    end
  end
endmodule

// File: rtl/kbd_event_decoder_chk.sv
module kbd_event_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_valid,
  input logic [7:0] byte_data,
  input logic       frame_err,
  input logic       repeat_squash,
  input logic       evt_valid,
  input logic [7:0] evt_code,
  input logic       evt_release,
  input logic       evt_repeat,
  input logic       evt_extended
);
  assert_event_needs_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(byte_valid && !frame_err));
  assert_code_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> evt_code == $past(byte_data));
  assert_break_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_data == 8'hF0) |=> !evt_valid);
  assert_ext_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_data == 8'hE0) |=> !evt_valid);
  assert_squash_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_repeat) |-> !$past(repeat_squash));
  assert_err_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !evt_valid);
  assert_release_no_repeat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> !(evt_release && evt_repeat));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> !evt_valid);
endmodule

bind kbd_event_decoder kbd_event_decoder_chk chk_i (.*);

// File: tb/kbd_event_decoder_tb_top.sv
`timescale 1ns/1ps
module kbd_event_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       frame_err = 1'b0;
  logic       repeat_squash = 1'b0;
  logic       evt_valid, evt_release, evt_repeat, evt_extended;
  logic [7:0] evt_code;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  kbd_event_decoder dut_i (.*);

  bit         m_held [256];
  bit         m_brk, m_ext;
  bit         x_valid, x_rel, x_rep, x_ext;
  logic [7:0] x_code;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_held[i]) m_held[i] = 1'b0;
      m_brk = 0; m_ext = 0; x_valid = 0;
      x_code = 0; x_rel = 0; x_rep = 0; x_ext = 0;
    end else begin
      x_valid = 0;
      if (frame_err) begin
        m_brk = 0; m_ext = 0;
      end else if (byte_valid) begin
        if (byte_data == 8'hF0) m_brk = 1;
        else if (byte_data == 8'hE0) m_ext = 1;
        else begin
          bit rep;
          rep = m_held[byte_data] && !m_brk;
          if (!(rep && repeat_squash)) begin
            x_valid = 1; x_code = byte_data;
            x_rel = m_brk; x_rep = rep; x_ext = m_ext;
          end
          m_held[byte_data] = !m_brk;
          m_brk = 0; m_ext = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(evt_valid == x_valid, x_valid ? "R2 valid" : "R10 valid", evt_valid, x_valid);
      if (x_valid && evt_valid) begin
        chk(evt_code == x_code, "R2 code", evt_code, x_code);
        chk(evt_release == x_rel, "R3 release", evt_release, x_rel);
        chk(evt_extended == x_ext, "R4 extended", evt_extended, x_ext);
        chk(evt_repeat == x_rep, "R5 repeat", evt_repeat, x_rep);
      end
    end
  end

  task automatic send(input logic [7:0] b, input bit err = 0);
    @(negedge clk);
    byte_valid = 1; byte_data = b; frame_err = err;
    @(negedge clk);
    byte_valid = 0; frame_err = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({evt_valid, evt_code, evt_release, evt_repeat, evt_extended} == 0, "R1 reset outputs",
        {evt_valid, evt_code, evt_release, evt_repeat, evt_extended}, 0);
    rst_n = 1;
    send(8'h1C); chk(evt_valid && !evt_repeat && !evt_release, "R5 first press", evt_repeat, 0);
    send(8'h1C); chk(evt_valid && evt_repeat, "R5 held press", evt_repeat, 1);
    send(8'hF0); chk(!evt_valid, "R3 prefix silent", evt_valid, 0);
    send(8'h1C); chk(evt_valid && evt_release && !evt_repeat, "R9 release", evt_release, 1);
    send(8'h1C); chk(evt_valid && !evt_repeat, "R6 press after release", evt_repeat, 0);
    send(8'hE0); chk(!evt_valid, "R4 prefix silent", evt_valid, 0);
    send(8'hF0); send(8'h75);
    chk(evt_valid && evt_release && evt_extended, "R4 E0 F0 code", {evt_release, evt_extended}, 3);
    repeat_squash = 1;
    send(8'h2B); chk(evt_valid && !evt_repeat, "R7 first press passes", evt_valid, 1);
    send(8'hE0); send(8'h2B); chk(!evt_valid, "R7 repeat dropped", evt_valid, 0);
    send(8'h33); chk(evt_valid && !evt_extended, "R7 ext consumed", evt_extended, 0);
    repeat_squash = 0;
    send(8'hF0);
    @(negedge clk) frame_err = 1; @(negedge clk) frame_err = 0;
    send(8'h2B); chk(evt_valid && !evt_release && evt_repeat, "R8 err clears break", evt_release, 0);
    send(8'h44, 1); chk(!evt_valid, "R8 byte with error", evt_valid, 0);
    send(8'h44); chk(evt_valid && !evt_repeat, "R8 map untouched", evt_repeat, 0);
    @(negedge clk);
    byte_valid = 1;
    for (int i = 0; i < 4000; i++) begin
      int s = $urandom_range(0, 9);
      byte_valid = ($urandom_range(0, 3) != 0);
      case (s)
        0, 1: byte_data = 8'hF0;
        2:    byte_data = 8'hE0;
        3:    byte_data = 8'h1C;
        4, 5: byte_data = 8'h2B;
        6:    byte_data = 8'h75;
        default: byte_data = 8'($urandom_range(0, 255));
      endcase
      frame_err = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 49) == 0) repeat_squash = ~repeat_squash;
      @(negedge clk);
    end
    byte_valid = 0; frame_err = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule